// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a countdown watchdog that sits on a simple register bus and pulls a system reset line when software stops servicing it. Software loads a tick count, then arms the block by writing a reset-configuration code into the arm register. While armed, the counter drops by one on every clock where the tick-enable input is high. If it reaches zero while still armed, the block drives a reset pulse for a fixed number of clocks, marks a hard-reset flag in the status register and disarms itself. Software keeps the system alive by reloading the count before it runs out.

Each write must carry the key byte 0x5A in bits 31:24, and the key is never stored. A write with any other key is dropped. The status register is cleared only by power-on reset, so it keeps its value across the reset pulse that the block itself issues. Its even bits 0 to 10 hold a six-bit boot-partition number, which the block decodes onto two output pins for the boot logic next to it. Partition 63 means "halt, do not reboot".

Requests use valid/ready. `req_ready` is high except while the reset pulse is active, and during that time every request stalls. An accepted read returns its data one cycle later with a single-cycle `rsp_valid`. Responses cannot be back-pressured, so the requester must take them. An accepted write returns no response.

Top module: `wdr_rstctl`

## Requirements
- R1: After power-on reset the arm, status and count registers all read 0, and `sys_rst`, `rsp_valid`, `boot_part` and `halt_req` are all 0.
- R2: A write changes no register unless its bits 31:24 equal 0x5A. Key bits always read back as 0.
- R3: The count register is at offset 0x24 and is 20 bits wide (bits 19:0). A write loads it from the written bits 19:0, and a read returns the ticks remaining.
- R4: While arm-register bit 5 is set, the count drops by one on each clock with `tick_en` high, and it stops at zero. While bit 5 is clear, the count holds.
- R5: The arm register is at offset 0x1C and is 12 bits wide. Bits 5:4 hold the reset configuration, and 2'b10 selects a full reset. The block is armed whenever bit 5 is set. Writing 0x5A000102 disarms it and reads back 0x102.
- R6: When the block is armed and the count is zero at a clock edge, `sys_rst` is high from the next cycle for exactly PULSE_CYCLES clocks. At the same edge, arm bits 5:4 clear and status bit 6 (hard reset) sets.
- R7: The status register is at offset 0x20 and is 12 bits wide. A keyed write stores the written bits 11:0. The value survives the watchdog reset and is cleared only by power-on reset.
- R8: `boot_part[k]` equals status bit 2k, for k = 0 to 5. `halt_req` is high exactly when that number is 63, which is status pattern 0x555.
- R9: Writing the count register while armed restarts the countdown from the written value.
- R10: `req_ready` is low while `sys_rst` is high, and requests offered then are not accepted. A read response comes one cycle after acceptance. An unmapped offset reads 0, and a write gives no response.
- R11: If a keyed status write lands in the expiry cycle, the status register takes the written bits with bit 6 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_en | input | 1 | Countdown tick strobe |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data, key in bits 31:24 |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| sys_rst | output | 1 | System reset pulse |
| boot_part | output | 6 | De-interleaved boot-partition number |
| halt_req | output | 1 | Partition 63 selected |

## Verification
Two things can update the status register in the same clock edge: a keyed software write and the expiry that sets the hard-reset flag. The bench forces this overlap. It loads a zero count and arms the block, so expiry falls on the very next edge, and it issues a status write at exactly that edge. The check passes if the later read shows the written bits with bit 6 also set. A count reload that falls on a tick edge is checked the same way: the read must return the reloaded value and not a decremented one.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam logic [7:0]  KEY_BYTE = 8'h5A;
  localparam logic [ADDR_W-1:0] OFS_ARM  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h24;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ARM  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdr_bus_dec.sv
module wdr_bus_dec
  import wdr_pkg::*;
#(
  parameter int unsigned WR_W = 20
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] arm_rd,
  input  logic [DATA_W-1:0] stat_rd,
  input  logic [DATA_W-1:0] cnt_rd,
  output logic              wr_arm,
  output logic              wr_stat,
  output logic              wr_cnt,
  output logic [WR_W-1:0]   wr_val,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  reg_sel_e sel;
  logic     accept;
  logic     key_ok;
  logic     wr_go;

  always_comb begin
    unique case (req_addr)
      OFS_ARM:  sel = SEL_ARM;
      OFS_STAT: sel = SEL_STAT;
      OFS_CNT:  sel = SEL_CNT;
      default:  sel = SEL_NONE;
    endcase
  end

  assign accept  = req_valid && req_ready;
  assign key_ok  = (req_wdata[DATA_W-1 -: 8] == KEY_BYTE);
  assign wr_go   = accept && req_write && key_ok;
  assign wr_arm  = wr_go && (sel == SEL_ARM);
  assign wr_stat = wr_go && (sel == SEL_STAT);
  assign wr_cnt  = wr_go && (sel == SEL_CNT);
  assign wr_val  = req_wdata[WR_W-1:0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write) begin
        unique case (sel)
          SEL_ARM:  rsp_rdata <= arm_rd;
          SEL_STAT: rsp_rdata <= stat_rd;
          SEL_CNT:  rsp_rdata <= cnt_rd;
          default:  rsp_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdr_countdown.sv
module wdr_countdown #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             armed,
  input  logic             tick_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic at_zero;

  assign at_zero = (count == '0);
  assign expire  = armed && at_zero;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (armed && tick_en && !at_zero) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdr_rst_pulse.sv
module wdr_rst_pulse #(
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic rst_out
);
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYCLES);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      left <= '0;
    end else if (fire) begin
      left <= PLOAD;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign rst_out = (left != '0);
endmodule

// File: rtl/wdr_part_decode.sv
module wdr_part_decode #(
  parameter int unsigned STAT_W    = 12,
  parameter int unsigned PART_BITS = 6
) (
  input  logic [STAT_W-1:0]    status,
  output logic [PART_BITS-1:0] part,
  output logic                 halt
);
  for (genvar k = 0; k < PART_BITS; k++) begin : g_gather
    assign part[k] = status[2*k];
  end
  assign halt = &part;
endmodule

// File: rtl/wdr_rstctl.sv
module wdr_rstctl
  import wdr_pkg::*;
#(
  parameter int unsigned CNT_W        = 20,
  parameter int unsigned ARM_W        = 12,
  parameter int unsigned STAT_W       = 12,
  parameter int unsigned PART_BITS    = 6,
  parameter int unsigned PULSE_CYCLES = 16,
  parameter int unsigned CFG_LSB      = 4,
  parameter int unsigned HARD_BIT     = 6
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 tick_en,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 sys_rst,
  output logic [PART_BITS-1:0] boot_part,
  output logic                 halt_req
);
  localparam int unsigned RUN_BIT = CFG_LSB + 1;

  logic              wr_arm, wr_stat, wr_cnt;
  logic [CNT_W-1:0]  wr_val;
  logic [ARM_W-1:0]  arm_q;
  logic [STAT_W-1:0] stat_q;
  logic [CNT_W-1:0]  count;
  logic              expire;
  logic              armed;

  assign armed     = arm_q[RUN_BIT];
  assign req_ready = !sys_rst;

  wdr_bus_dec #(.WR_W(CNT_W)) u_dec (
    .clk       (clk),
    .por_n     (por_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .arm_rd    (DATA_W'(arm_q)),
    .stat_rd   (DATA_W'(stat_q)),
    .cnt_rd    (DATA_W'(count)),
    .wr_arm    (wr_arm),
    .wr_stat   (wr_stat),
    .wr_cnt    (wr_cnt),
    .wr_val    (wr_val),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  wdr_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .por_n    (por_n),
    .armed    (armed),
    .tick_en  (tick_en),
    .load     (wr_cnt),
    .load_val (wr_val),
    .count    (count),
    .expire   (expire)
  );

  wdr_rst_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk     (clk),
    .por_n   (por_n),
    .fire    (expire),
    .rst_out (sys_rst)
  );

  // Arm register: software write first, expiry clears the configuration field.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      arm_q <= '0;
    end else begin
      if (wr_arm) arm_q <= wr_val[ARM_W-1:0];
      if (expire) arm_q[RUN_BIT:CFG_LSB] <= 2'b00;
    end
  end

  // Status register: power-on reset only; expiry flag wins over the written bit.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stat_q <= '0;
    end else begin
      if (wr_stat) stat_q <= wr_val[STAT_W-1:0];
      if (expire)  stat_q[HARD_BIT] <= 1'b1;
    end
  end

  wdr_part_decode #(.STAT_W(STAT_W), .PART_BITS(PART_BITS)) u_part (
    .status (stat_q),
    .part   (boot_part),
    .halt   (halt_req)
  );
endmodule

// File: rtl/wdr_rstctl_chk.sv
module wdr_rstctl_chk
  import wdr_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned ARM_W  = 12,
  parameter int unsigned STAT_W = 12
) (
  input logic              clk,
  input logic              por_n,
  input logic              tick_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              armed,
  input logic [CNT_W-1:0]  count,
  input logic              wr_cnt,
  input logic [ARM_W-1:0]  arm_q,
  input logic [STAT_W-1:0] stat_q,
  input logic              sys_rst
);
  logic zero_armed;
  assign zero_armed = armed && (count == '0);

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!por_n)
    (armed && tick_en && (count != '0) && !wr_cnt) |=> (count == $past(count) - 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
    (!armed && !wr_cnt) |=> $stable(count));

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> ($past(armed) && ($past(count) == '0)));

  assert_hard_flag_R6: assert property (@(posedge clk) disable iff (!por_n)
    zero_armed |=> stat_q[6]);

  assert_disarm_R6: assert property (@(posedge clk) disable iff (!por_n)
    zero_armed |=> !arm_q[5]);

  assert_stall_R10: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |-> !req_ready);

  assert_bad_key_R2: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid && req_ready && req_write && (req_addr == OFS_ARM) &&
     (req_wdata[31:24] != KEY_BYTE) && !zero_armed) |=> $stable(arm_q));
endmodule

bind wdr_rstctl wdr_rstctl_chk #(.CNT_W(CNT_W), .ARM_W(ARM_W), .STAT_W(STAT_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .tick_en   (tick_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .armed     (armed),
  .count     (count),
  .wr_cnt    (wr_cnt),
  .arm_q     (arm_q),
  .stat_q    (stat_q),
  .sys_rst   (sys_rst)
);

// File: tb/wdr_rstctl_test.sv
module wdr_rstctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 16;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sys_rst;
  logic [5:0]  boot_part;
  logic        halt_req;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdr_rstctl #(.PULSE_CYCLES(PULSE)) uut (
    .clk(clk), .por_n(por_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sys_rst(sys_rst), .boot_part(boot_part), .halt_req(halt_req)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  tag;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd1,  8'h1C, 32'h0,          32'h0},        // R1 arm reads 0
    '{1'b0, 4'd1,  8'h20, 32'h0,          32'h0},        // R1 status reads 0
    '{1'b0, 4'd1,  8'h24, 32'h0,          32'h0},        // R1 count reads 0
    '{1'b1, 4'd2,  8'h1C, 32'hA5000030,   32'h0},        // R2 wrong key
    '{1'b0, 4'd2,  8'h1C, 32'h0,          32'h0},
    '{1'b1, 4'd7,  8'h20, 32'h5A000555,   32'h0},        // R7 status write
    '{1'b0, 4'd7,  8'h20, 32'h0,          32'h00000555},
    '{1'b1, 4'd3,  8'h24, 32'h5AF12345,   32'h0},        // R3 upper bits dropped
    '{1'b0, 4'd3,  8'h24, 32'h0,          32'h00012345},
    '{1'b1, 4'd2,  8'h24, 32'h00000077,   32'h0},        // R2 no key on count
    '{1'b0, 4'd2,  8'h24, 32'h0,          32'h00012345},
    '{1'b1, 4'd5,  8'h1C, 32'h5A000102,   32'h0},        // R5 disarm code
    '{1'b0, 4'd5,  8'h1C, 32'h0,          32'h00000102},
    '{1'b0, 4'd10, 8'h30, 32'h0,          32'h0},        // R10 unmapped
    '{1'b1, 4'd7,  8'h20, 32'h5A000000,   32'h0},
    '{1'b0, 4'd7,  8'h20, 32'h0,          32'h0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d; logic v;
    bus_read(a, d, v);
    check(v && (d == e), tag, d, e);
  endtask

  task automatic wait_pulse_end();
    while (sys_rst) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d; logic v;
    int k; int n;
    repeat (3) @(negedge clk);
    check(!sys_rst && !rsp_valid && boot_part == 0 && !halt_req, "R1",
          {sys_rst, rsp_valid, halt_req, boot_part}, 32'h0);
    por_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        bus_write(VECS[i].addr, VECS[i].data);
        check(!rsp_valid, "R10", {31'b0, rsp_valid}, 32'h0);
      end else begin
        bus_read(VECS[i].addr, d, v);
        checks++;
        if (!(v && d == VECS[i].exp)) begin
          fails++;
          $display("FAIL R%0d vector %0d actual=0x%08h expected=0x%08h",
                   VECS[i].tag, i, d, VECS[i].exp);
        end
      end
    end
    @(negedge clk);
    check(!rsp_valid, "R10", {31'b0, rsp_valid}, 32'h0);

    // R8 partition decode
    bus_write(8'h20, 32'h5A000555);
    check(boot_part == 6'd63 && halt_req, "R8", {25'b0, halt_req, boot_part}, 32'h7F);
    bus_write(8'h20, 32'h5A000041);
    check(boot_part == 6'd9 && !halt_req, "R8", {25'b0, halt_req, boot_part}, 32'h09);
    bus_write(8'h20, 32'h5A000004);
    check(boot_part == 6'd2, "R8", {26'b0, boot_part}, 32'h02);

    // R4 hold while disarmed, and while armed without ticks
    bus_write(8'h24, 32'h5A000007);
    tick_en = 1'b1;
    repeat (20) @(negedge clk);
    expect_read(8'h24, 32'h7, "R4");
    tick_en = 1'b0;
    bus_write(8'h1C, 32'h5A000020);
    repeat (10) @(negedge clk);
    expect_read(8'h24, 32'h7, "R4");
    bus_write(8'h1C, 32'h5A000102);

    // R9 reload while armed
    bus_write(8'h24, 32'h5A00000A);
    tick_en = 1'b1;
    bus_write(8'h1C, 32'h5A000020);
    repeat (5) @(negedge clk);
    bus_write(8'h24, 32'h5A00000A);
    expect_read(8'h24, 32'hA, "R9");
    tick_en = 1'b0;
    bus_write(8'h1C, 32'h5A000102);
    check(!sys_rst, "R9", {31'b0, sys_rst}, 32'h0);

    // R6 expiry: count 5, ticking every clock
    bus_write(8'h20, 32'h5A000001);
    bus_write(8'h24, 32'h5A000005);
    tick_en = 1'b1;
    bus_write(8'h1C, 32'h5A000020);
    k = 0;
    while (!sys_rst && k < 50) begin @(negedge clk); k++; end
    check(k == 6, "R6", k, 6);
    check(!req_ready, "R10", {31'b0, req_ready}, 32'h0);
    n = 0;
    while (sys_rst && n < 100) begin
      n++;
      if (n == 2) begin req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h20; req_wdata = 32'h5A000FFF; end
      @(negedge clk);
    end
    req_valid = 1'b0; req_write = 1'b0;
    check(n == PULSE, "R6", n, PULSE);
    tick_en = 1'b0;
    expect_read(8'h1C, 32'h0, "R6");
    expect_read(8'h20, 32'h41, "R7");
    expect_read(8'h24, 32'h0, "R4");

    // R11 status write in the expiry cycle
    bus_write(8'h24, 32'h5A000000);
    bus_write(8'h1C, 32'h5A000020);
    bus_write(8'h20, 32'h5A000010);
    check(sys_rst, "R11", {31'b0, sys_rst}, 32'h1);
    wait_pulse_end();
    expect_read(8'h20, 32'h50, "R11");

    // R1 power-on reset clears status
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    expect_read(8'h20, 32'h0, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule